// File: doc/BRIEF.md
# Victim Replication L2 Slice Controller

This block steers requests and fills for one slice of a shared, distributed second-level cache. When the local first-level cache evicts a line, the controller may keep a copy in the local slice. It keeps the copy only if the target set still has an empty way, and it never pushes out a valid line to make room. A victim whose home slice is another slice becomes a replica. A victim whose home is this slice refreshes or creates the home copy. Every stored line carries a flag that says which kind it is.

When the first-level cache misses, the controller looks up the local slice first. A hit is answered locally. If the hit line is a replica, the replica is dropped because the line moves back into the first-level cache. A local miss is forwarded on the network to the home slice, which is chosen from the address bits just above the line offset. Only one miss is outstanding at a time. The core stays in the sharer list of every line it replicates, so an invalidation from outside clears any matching replica.

The eviction, miss, forward and response interfaces use valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. While valid is high without ready, the sender keeps valid and its payload unchanged. The controller does the same on its own outputs while they are back-pressured. The invalidation input and the home-response input are plain strobes and have no back-pressure.

Top module: `vr_slice_ctrl`

## Requirements
- R1: An evicted line whose address is not stored, and whose set (address bits [8:6]) has an empty way, is stored. A later miss to that line is answered locally with the evicted data.
- R2: An eviction to a set whose two ways are both valid, and which matches neither of them, is dropped. Both lines already in the set stay readable.
- R3: A miss that hits locally produces `l1rsp_valid` with `l1rsp_local`=1 on the edge after it is accepted, and raises no forward request.
- R4: A miss that misses locally raises `fwd_valid` on the edge after it is accepted. `fwd_addr` equals the miss address, and `fwd_slice` equals address bits [7:6] (64-byte lines, 4 slices). The data from the home response is then returned with `l1rsp_local`=0.
- R5: An invalidation removes a matching replica. It leaves a home copy in place.
- R6: A victim whose home slice (address bits [7:6]) equals `MY_SLICE` (default 0) is kept as a home copy. A hit on a home copy leaves it stored. A later eviction of the same line overwrites its data.
- R7: A local hit on a replica removes the replica, so the next miss to that line is forwarded.
- R8: After a miss is accepted, `mreq_ready` stays low until that miss's response has been taken by the first-level cache.
- R9: Only one input is served per cycle, in the order invalidation, then eviction, then miss. `ev_ready` is low while `inv_valid` is high. `mreq_ready` is low while `inv_valid` or `ev_valid` is high.
- R10: While `fwd_valid` is high and `fwd_ready` is low, `fwd_valid`, `fwd_addr` and `fwd_slice` hold.
- R11: While `l1rsp_valid` is high and `l1rsp_ready` is low, `l1rsp_valid`, `l1rsp_data` and `l1rsp_local` hold.
- R12: After reset, no line is stored, `fwd_valid` and `l1rsp_valid` are low, and both ready outputs are high when no input is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | First-level victim offered |
| ev_ready | output | 1 | Victim accepted this cycle |
| ev_addr | input | ADDR_W | Byte address of the victim |
| ev_data | input | DATA_W | Line payload of the victim |
| mreq_valid | input | 1 | First-level miss offered |
| mreq_ready | output | 1 | Miss accepted this cycle |
| mreq_addr | input | ADDR_W | Byte address of the miss |
| l1rsp_valid | output | 1 | Response to the first-level cache valid |
| l1rsp_ready | input | 1 | First-level cache takes the response |
| l1rsp_data | output | DATA_W | Response payload |
| l1rsp_local | output | 1 | 1 = served by the local slice, 0 = from the home slice |
| fwd_valid | output | 1 | Forward request to the network valid |
| fwd_ready | input | 1 | Network takes the forward request |
| fwd_addr | output | ADDR_W | Forwarded miss address |
| fwd_slice | output | log2(SLICES) | Home slice number |
| home_rsp_valid | input | 1 | Data returned from the home slice |
| home_rsp_data | input | DATA_W | Returned payload |
| inv_valid | input | 1 | Invalidation strobe |
| inv_addr | input | ADDR_W | Address being invalidated |

## Verification
The assertions assume that `home_rsp_valid` is asserted only while a forwarded request is waiting, for a single cycle. They also assume that each sender holds its valid and payload until ready, as the handshake rules require. The bench raises the home response once per forwarded miss, only after the forward handshake has completed. Every task holds its valid until it sees ready at a falling edge, then drops it one edge later. Invalidations are one-cycle pulses. The response and forward readies are held low for a few cycles on purpose, so that the hold rules are exercised.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {MS_IDLE, MS_SEND, MS_WAIT} miss_st_t;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_CLEAR} arr_op_t;
endpackage

// File: rtl/vr_first_free.sv
module vr_first_free #(
  parameter int WAYS = 2,
  localparam int IW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] free_vec,
  output logic            any_free,
  output logic [IW-1:0]   pick
);
  // lowest-numbered empty way wins
  always_comb begin
    pick = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_vec[w]) pick = IW'(w);
    end
  end
  assign any_free = |free_vec;
endmodule

// File: rtl/vr_tag_array.sv
module vr_tag_array #(
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 23,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int IW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SET_W-1:0]     lk_set,
  input  logic [TAG_W-1:0]     lk_tag,
  output logic                 hit,
  output logic [IW-1:0]        hit_way,
  output logic                 hit_rep,
  output logic [DATA_W-1:0]    hit_data,
  output logic                 free_any,
  output logic [IW-1:0]        free_way,
  input  vr_pkg::arr_op_t      op,
  input  logic [IW-1:0]        op_way,
  input  logic                 op_rep,
  input  logic [DATA_W-1:0]    op_data
);
  logic [WAYS-1:0]   hit_vec, free_vec, rep_vec;
  logic [DATA_W-1:0] dat_vec [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   v_q, r_q;
    logic [TAG_W-1:0]  t_q [SETS];
    logic [DATA_W-1:0] d_q [SETS];
    wire sel = (op_way == IW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        r_q <= '0;
      end else if (op != vr_pkg::OP_NONE && sel) begin
        v_q[lk_set] <= (op == vr_pkg::OP_WRITE);
        r_q[lk_set] <= op_rep;
      end
    end

    always_ff @(posedge clk) begin
      if (op == vr_pkg::OP_WRITE && sel) begin
        t_q[lk_set] <= lk_tag;
        d_q[lk_set] <= op_data;
      end
    end

    assign hit_vec[w]  = v_q[lk_set] && (t_q[lk_set] == lk_tag);
    assign free_vec[w] = !v_q[lk_set];
    assign rep_vec[w]  = r_q[lk_set];
    assign dat_vec[w]  = d_q[lk_set];
  end

  always_comb begin
    hit_way  = '0;
    hit_rep  = 1'b0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = IW'(w);
        hit_rep  = rep_vec[w];
        hit_data = dat_vec[w];
      end
    end
  end
  assign hit = |hit_vec;

  vr_first_free #(.WAYS(WAYS)) u_free (
    .free_vec (free_vec),
    .any_free (free_any),
    .pick     (free_way)
  );

  // a line address may live in at most one way (R1, R2 fills never duplicate)
  p_unique_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/vr_miss_ctrl.sv
module vr_miss_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF    = 6,
  parameter int SW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_valid,
  output logic              mreq_ready,
  input  logic [ADDR_W-1:0] mreq_addr,
  input  logic              blocked,
  output logic              fire,
  input  logic              local_hit,
  input  logic [DATA_W-1:0] local_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SW-1:0]     fwd_slice,
  input  logic              home_rsp_valid,
  input  logic [DATA_W-1:0] home_rsp_data,
  output logic              l1rsp_valid,
  input  logic              l1rsp_ready,
  output logic [DATA_W-1:0] l1rsp_data,
  output logic              l1rsp_local
);
  vr_pkg::miss_st_t st_q;

  assign mreq_ready = (st_q == vr_pkg::MS_IDLE) && !l1rsp_valid && !blocked;
  assign fire       = mreq_valid && mreq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= vr_pkg::MS_IDLE;
      fwd_valid   <= 1'b0;
      fwd_addr    <= '0;
      fwd_slice   <= '0;
      l1rsp_valid <= 1'b0;
      l1rsp_data  <= '0;
      l1rsp_local <= 1'b0;
    end else begin
      if (l1rsp_valid && l1rsp_ready) l1rsp_valid <= 1'b0;
      case (st_q)
        vr_pkg::MS_IDLE: if (fire) begin
          if (local_hit) begin
            l1rsp_valid <= 1'b1;
            l1rsp_data  <= local_data;
            l1rsp_local <= 1'b1;
          end else begin
            st_q      <= vr_pkg::MS_SEND;
            fwd_valid <= 1'b1;
            fwd_addr  <= mreq_addr;
            fwd_slice <= mreq_addr[OFF +: SW];
          end
        end
        vr_pkg::MS_SEND: if (fwd_ready) begin
          fwd_valid <= 1'b0;
          st_q      <= vr_pkg::MS_WAIT;
        end
        vr_pkg::MS_WAIT: if (home_rsp_valid) begin
          l1rsp_valid <= 1'b1;
          l1rsp_data  <= home_rsp_data;
          l1rsp_local <= 1'b0;
          st_q        <= vr_pkg::MS_IDLE;
        end
        default: st_q <= vr_pkg::MS_IDLE;
      endcase
    end
  end

  p_single_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !mreq_ready);
  p_fwd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_slice));
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    l1rsp_valid && !l1rsp_ready |=> l1rsp_valid && $stable(l1rsp_data) && $stable(l1rsp_local));
  p_fwd_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_slice == fwd_addr[OFF +: SW]);
endmodule

// File: rtl/vr_slice_ctrl.sv
module vr_slice_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SLICES     = 4,
  parameter int SETS       = 8,
  parameter int WAYS       = 2,
  parameter int MY_SLICE   = 0,
  localparam int OFF   = $clog2(LINE_BYTES),
  localparam int SW    = $clog2(SLICES),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF - SET_W,
  localparam int IW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              mreq_valid,
  output logic              mreq_ready,
  input  logic [ADDR_W-1:0] mreq_addr,
  output logic              l1rsp_valid,
  input  logic              l1rsp_ready,
  output logic [DATA_W-1:0] l1rsp_data,
  output logic              l1rsp_local,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SW-1:0]     fwd_slice,
  input  logic              home_rsp_valid,
  input  logic [DATA_W-1:0] home_rsp_data,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit, lk_rep, free_any, home_here, miss_fire, do_ev;
  logic [IW-1:0]     hit_way, free_way, op_way;
  logic [DATA_W-1:0] hit_data;
  vr_pkg::arr_op_t   op;

  // one requester owns the lookup port per cycle
  assign lk_addr   = inv_valid ? inv_addr : (ev_valid ? ev_addr : mreq_addr);
  assign home_here = (lk_addr[OFF +: SW] == SW'(MY_SLICE));
  assign ev_ready  = !inv_valid;
  assign do_ev     = ev_valid && !inv_valid;
  wire unused_lo   = ^lk_addr[OFF-1:0];

  always_comb begin
    op     = vr_pkg::OP_NONE;
    op_way = hit_way;
    if (inv_valid) begin
      if (lk_hit && lk_rep) op = vr_pkg::OP_CLEAR;
    end else if (do_ev) begin
      if (lk_hit) op = vr_pkg::OP_WRITE;
      else if (free_any) begin
        op     = vr_pkg::OP_WRITE;
        op_way = free_way;
      end
    end else if (miss_fire && lk_hit && lk_rep) begin
      op = vr_pkg::OP_CLEAR;
    end
  end

  vr_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (lk_addr[OFF +: SET_W]),
    .lk_tag   (lk_addr[ADDR_W-1 : OFF+SET_W]),
    .hit      (lk_hit),
    .hit_way  (hit_way),
    .hit_rep  (lk_rep),
    .hit_data (hit_data),
    .free_any (free_any),
    .free_way (free_way),
    .op       (op),
    .op_way   (op_way),
    .op_rep   (!home_here),
    .op_data  (ev_data)
  );

  vr_miss_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF(OFF), .SW(SW)) u_miss (
    .clk            (clk),
    .rst_n          (rst_n),
    .mreq_valid     (mreq_valid),
    .mreq_ready     (mreq_ready),
    .mreq_addr      (mreq_addr),
    .blocked        (inv_valid || ev_valid),
    .fire           (miss_fire),
    .local_hit      (lk_hit),
    .local_data     (hit_data),
    .fwd_valid      (fwd_valid),
    .fwd_ready      (fwd_ready),
    .fwd_addr       (fwd_addr),
    .fwd_slice      (fwd_slice),
    .home_rsp_valid (home_rsp_valid),
    .home_rsp_data  (home_rsp_data),
    .l1rsp_valid    (l1rsp_valid),
    .l1rsp_ready    (l1rsp_ready),
    .l1rsp_data     (l1rsp_data),
    .l1rsp_local    (l1rsp_local)
  );

  p_hit_no_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && lk_hit |=> l1rsp_valid && l1rsp_local && !fwd_valid);
  p_inv_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !mreq_ready && !miss_fire);
endmodule

// File: tb/vr_slice_ctrl_tb_top.sv
module vr_slice_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        ev_valid = 0, mreq_valid = 0, l1rsp_ready = 0, fwd_ready = 0;
  logic        home_rsp_valid = 0, inv_valid = 0;
  logic [31:0] ev_addr = 0, ev_data = 0, mreq_addr = 0, home_rsp_data = 0, inv_addr = 0;
  logic        ev_ready, mreq_ready, l1rsp_valid, l1rsp_local, fwd_valid;
  logic [31:0] l1rsp_data, fwd_addr;
  logic [1:0]  fwd_slice;

  vr_slice_ctrl dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: stored lines keyed by line address
  int unsigned m_data [int];
  bit          m_rep  [int];
  bit          m_pend, m_req_v, m_rsp_v, m_rsp_loc;
  logic [31:0] m_req_addr, m_rsp_data;
  int          ln;
  bit          waiting, mr, mf;

  function automatic int set_count(int line);
    int c = 0;
    foreach (m_data[k]) if ((k % 8) == (line % 8)) c++;
    return c;
  endfunction
  function automatic bit exp_miss_ready();
    return !(m_pend || m_rsp_v || inv_valid || ev_valid);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data.delete(); m_rep.delete();
      m_pend = 0; m_req_v = 0; m_rsp_v = 0; m_rsp_loc = 0; m_req_addr = 0; m_rsp_data = 0;
    end else begin
      waiting = m_pend && !m_req_v;
      mr = exp_miss_ready();
      mf = mreq_valid && mr;
      if (m_rsp_v && l1rsp_ready) m_rsp_v = 0;
      if (m_req_v && fwd_ready) m_req_v = 0;
      if (waiting && home_rsp_valid) begin
        m_rsp_v = 1; m_rsp_data = home_rsp_data; m_rsp_loc = 0; m_pend = 0;
      end
      if (inv_valid) begin
        ln = int'(inv_addr >> 6);
        if (m_data.exists(ln) && m_rep[ln]) begin m_data.delete(ln); m_rep.delete(ln); end
      end else if (ev_valid) begin
        ln = int'(ev_addr >> 6);
        if (m_data.exists(ln)) m_data[ln] = ev_data;
        else if (set_count(ln) < 2) begin m_data[ln] = ev_data; m_rep[ln] = (ln % 4) != 0; end
      end
      if (mf) begin
        ln = int'(mreq_addr >> 6);
        if (m_data.exists(ln)) begin
          m_rsp_v = 1; m_rsp_data = m_data[ln]; m_rsp_loc = 1;
          if (m_rep[ln]) begin m_data.delete(ln); m_rep.delete(ln); end
        end else begin
          m_pend = 1; m_req_v = 1; m_req_addr = mreq_addr;
        end
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      check(ev_ready == !inv_valid, "R9 ev_ready", ev_ready, !inv_valid);
      check(mreq_ready == exp_miss_ready(), "R8 mreq_ready", mreq_ready, exp_miss_ready());
      check(fwd_valid == m_req_v, "R10 fwd_valid", fwd_valid, m_req_v);
      if (m_req_v) begin
        check(fwd_addr == m_req_addr, "R4 fwd_addr", fwd_addr, m_req_addr);
        check(fwd_slice == m_req_addr[7:6], "R4 fwd_slice", fwd_slice, m_req_addr[7:6]);
      end
      check(l1rsp_valid == m_rsp_v, "R11 l1rsp_valid", l1rsp_valid, m_rsp_v);
      if (m_rsp_v) begin
        check(l1rsp_data == m_rsp_data, "R3 l1rsp_data", l1rsp_data, m_rsp_data);
        check(l1rsp_local == m_rsp_loc, "R3 l1rsp_local", l1rsp_local, m_rsp_loc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic evict(input int line, input logic [31:0] d);
    @(posedge clk); #1 ev_valid = 1; ev_addr = line << 6; ev_data = d;
    @(negedge clk); while (!ev_ready) @(negedge clk);
    @(posedge clk); #1 ev_valid = 0;
  endtask

  task automatic inval(input int line);
    @(posedge clk); #1 inv_valid = 1; inv_addr = (line << 6) | 32'h14;
    @(posedge clk); #1 inv_valid = 0;
  endtask

  task automatic miss(input int line, input bit exp_loc, input logic [31:0] exp_d, input string tag);
    logic [31:0] a = (line << 6) | 32'h8;
    logic [31:0] nd = 32'hF000_0000 | a;
    bit got_loc; logic [31:0] got_d;
    @(posedge clk); #1 mreq_valid = 1; mreq_addr = a;
    @(negedge clk); while (!mreq_ready) @(negedge clk);
    @(posedge clk); #1 mreq_valid = 0;
    @(negedge clk);
    if (fwd_valid) begin
      check(!mreq_ready, {tag, " R8 busy while forwarded"}, mreq_ready, 0);
      check(fwd_slice == a[7:6], {tag, " R4 home slice"}, fwd_slice, a[7:6]);
      repeat (2) @(negedge clk);
      @(posedge clk); #1 fwd_ready = 1;
      @(posedge clk); #1 fwd_ready = 0;
      repeat (2) @(posedge clk);
      #1 home_rsp_valid = 1; home_rsp_data = nd;
      @(posedge clk); #1 home_rsp_valid = 0;
      @(negedge clk);
    end
    got_loc = l1rsp_local; got_d = l1rsp_data;
    check(l1rsp_valid, {tag, " response present"}, l1rsp_valid, 1);
    check(got_loc == exp_loc, {tag, " local flag"}, got_loc, exp_loc);
    check(got_d == (exp_loc ? exp_d : nd), {tag, " data"}, got_d, exp_loc ? exp_d : nd);
    @(negedge clk);
    @(posedge clk); #1 l1rsp_ready = 1;
    @(posedge clk); #1 l1rsp_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!l1rsp_valid && !fwd_valid, "R12 outputs idle after reset", {l1rsp_valid, fwd_valid}, 0);
    check(mreq_ready && ev_ready, "R12 readies after reset", {mreq_ready, ev_ready}, 2'b11);
    cmp_en = 1;
    miss(32'h11, 0, 0, "R12 empty after reset, R4 forward");
    evict(32'h11, 32'h1111);
    miss(32'h11, 1, 32'h1111, "R1 replica hit");
    miss(32'h11, 0, 0, "R7 replica gone after hit");
    evict(32'h21, 32'h2121);
    evict(32'h31, 32'h3131);
    evict(32'h41, 32'h4141);
    miss(32'h41, 0, 0, "R2 full-set victim dropped");
    miss(32'h21, 1, 32'h2121, "R2 first line kept");
    miss(32'h31, 1, 32'h3131, "R2 second line kept");
    evict(32'h51, 32'h5151);
    inval(32'h51);
    miss(32'h51, 0, 0, "R5 replica invalidated");
    evict(32'h14, 32'hAAAA);
    inval(32'h14);
    miss(32'h14, 1, 32'hAAAA, "R5 home copy survives invalidation");
    miss(32'h14, 1, 32'hAAAA, "R6 home copy kept after hit");
    evict(32'h14, 32'hBBBB);
    miss(32'h14, 1, 32'hBBBB, "R6 home copy overwritten");
    // R9 arbitration
    @(posedge clk); #1 inv_valid = 1; inv_addr = 32'h7 << 6;
    ev_valid = 1; ev_addr = 32'h66 << 6; ev_data = 32'h6666;
    mreq_valid = 1; mreq_addr = 32'h12 << 6;
    @(negedge clk);
    check(!ev_ready, "R9 evict blocked by invalidation", ev_ready, 0);
    check(!mreq_ready, "R9 miss blocked by invalidation", mreq_ready, 0);
    @(posedge clk); #1 inv_valid = 0;
    @(negedge clk);
    check(ev_ready, "R9 evict served after invalidation", ev_ready, 1);
    check(!mreq_ready, "R9 miss blocked by evict", mreq_ready, 0);
    @(posedge clk); #1 ev_valid = 0; mreq_valid = 0;
    miss(32'h66, 1, 32'h6666, "R9 evict took effect");
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule